// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block turns a virtual address into a physical page base by reading page-table entries from memory, one level at a time. A translation request carries the virtual address, a supervisor flag and the access kind (fetch or store; neither means a load). The walk starts at the table whose base is given on `root_base`. For each level the walker issues one word read on a request/response memory port and waits for the reply. It then either descends into the next table or treats the entry as a leaf.

At a leaf the walker checks permissions. On success it writes the entry back with the referenced bit set, and also the dirty bit for a store. It then reports the 4 KiB page base. A leaf found above the last level maps a large page. The walker folds the untranslated virtual page bits into the returned base, so the caller always receives a 4 KiB translation. Sign-extension, table-address bounds and final-address bounds failures all end the walk with a fault. The geometry is set by the `XLEN` parameter: 64 selects three levels, and 32 selects two.

Top module: `ptw_walker`

## Requirements
- R1: With XLEN=64 the walk has 3 levels with 9-bit indices, 8-byte entries and the physical page number at entry bit 26. With XLEN=32 it has 2 levels with 10-bit indices, 4-byte entries and the page number at bit 10. The page shift is 12 in both.
- R2: When the address bits from VA width-1 upward are neither all zeros nor all ones, the walk ends with a fault. `walk_done` rises in the cycle right after acceptance and no memory request is made. VA width is 39 with XLEN=64.
- R3: Level 0 reads `root_base + index*word_bytes`. The index of level k is the virtual page number shifted right by (levels-1-k)*index_bits and masked to the index width.
- R4: If an entry address is at or above `MEM_BYTES`, no request is issued for it and the walk faults.
- R5: An entry with bit 0 (valid) set and bits 4:1 equal to 0 is a pointer to the next table, whose base is the page number shifted left by 12. A pointer at the last level is a fault.
- R6: Any other entry is a leaf. It passes when bit 0 is set, a store has bit 2 set, a fetch has bit 3 set, and a non-supervisor access has bit 4 set. A failing leaf faults with no write.
- R7: A passing leaf is written back to its own address with bit 5 set, and with bit 6 also set for a store.
- R8: For a leaf at level k, the result is (page number OR the low (levels-1-k)*index_bits bits of the virtual page number) shifted left by 12.
- R9: If that result is at or above `MEM_BYTES`, the walk faults after the write-back.
- R10: A request holds its valid, address and kind until `mem_req_ready`. A read then waits for `mem_rsp_valid`, and a write completes on acceptance.
- R11: `walk_done` is a one-cycle pulse. `walk_pbase` is 0 on a fault. With no stall, a walk ending at level k is done 2k+1 cycles after acceptance on a bound fault, 2k+2 on a leaf or pointer fault, and 2k+3 after a write-back.
- R12: A walk is accepted only while `walk_ready` is high. `walk_ready` is low from acceptance until `walk_done`, and requests arriving then are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| walk_valid | input | 1 | Translation request |
| walk_ready | output | 1 | Walker idle, request accepted |
| walk_vaddr | input | XLEN | Virtual address |
| walk_super | input | 1 | Supervisor access |
| walk_fetch | input | 1 | Instruction fetch |
| walk_store | input | 1 | Store access |
| root_base | input | XLEN | Byte address of the top-level table |
| walk_done | output | 1 | Result pulse |
| walk_fault | output | 1 | Walk failed |
| walk_pbase | output | XLEN | 4 KiB physical page base |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | XLEN | Entry byte address |
| mem_req_wdata | output | XLEN | Updated entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | XLEN | Entry read |

## Verification
Every result has a fixed due cycle counted from the acceptance edge. A sign fault is due at once. A bound fault at level k is due after 2k+1 edges, a failing leaf or last-level pointer after 2k+2, and a completed write-back after 2k+3. A request stall delays all of these by the stall length. The bench model gives each walk its due cycle and checks `walk_done` and `walk_ready` on every falling edge, so an early or late pulse is caught. It compares fault and page base in the due cycle, and checks the write-back log once the walk has ended.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int PAGE_SHIFT = 12;
    localparam int PTE_VALID  = 0;
    localparam int PTE_KIND_LO = 1;
    localparam int PTE_KIND_HI = 4;
    localparam int PTE_WR     = 2;
    localparam int PTE_EX     = 3;
    localparam int PTE_USR    = 4;
    localparam int PTE_REF    = 5;
    localparam int PTE_DIRTY  = 6;
    localparam logic [3:0] KIND_TABLE = 4'd0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_WRITE
    } walk_state_e;
endpackage

// File: rtl/ptw_index.sv
module ptw_index
    import ptw_pkg::*;
#(
    parameter int          XLEN      = 64,
    parameter int          LEVELS    = 3,
    parameter int          IDX_BITS  = 9,
    parameter int          LVL_W     = 2,
    parameter logic [63:0] MEM_BYTES = 64'h100_0000
) (
    input  logic [XLEN-1:0]  vaddr,
    input  logic [XLEN-1:0]  base,
    input  logic [LVL_W-1:0] level,
    output logic [XLEN-1:0]  pte_addr,
    output logic             in_bounds
);
    localparam int WORD_SHIFT = $clog2(XLEN / 8);
    localparam logic [XLEN-1:0] IDX_MASK = (XLEN'(1) << IDX_BITS) - XLEN'(1);

    logic [XLEN-1:0] vpn;
    logic [XLEN-1:0] idx;
    int              shamt;

    always_comb begin
        vpn       = vaddr >> PAGE_SHIFT;
        shamt     = (LEVELS - 1 - int'(level)) * IDX_BITS;
        idx       = (vpn >> shamt) & IDX_MASK;
        pte_addr  = base + (idx << WORD_SHIFT);
        in_bounds = 64'(pte_addr) < MEM_BYTES;
    end
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf
    import ptw_pkg::*;
#(
    parameter int          XLEN      = 64,
    parameter int          LEVELS    = 3,
    parameter int          IDX_BITS  = 9,
    parameter int          PPN_LSB   = 26,
    parameter int          LVL_W     = 2,
    parameter logic [63:0] MEM_BYTES = 64'h100_0000
) (
    input  logic [XLEN-1:0]  pte,
    input  logic [XLEN-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    input  logic             sup,
    input  logic             fetch,
    input  logic             store,
    output logic             is_table,
    output logic             perm_ok,
    output logic [XLEN-1:0]  pte_upd,
    output logic [XLEN-1:0]  next_base,
    output logic [XLEN-1:0]  page_base,
    output logic             pa_ok
);
    logic [XLEN-1:0] ppn;
    logic [XLEN-1:0] vpn;
    logic [XLEN-1:0] low_mask;
    int              shamt;

    always_comb begin
        ppn      = pte >> PPN_LSB;
        vpn      = vaddr >> PAGE_SHIFT;
        shamt    = (LEVELS - 1 - int'(level)) * IDX_BITS;
        low_mask = (XLEN'(1) << shamt) - XLEN'(1);

        is_table = pte[PTE_VALID] && (pte[PTE_KIND_HI:PTE_KIND_LO] == KIND_TABLE);
        perm_ok  = pte[PTE_VALID]
                && (!store || pte[PTE_WR])
                && (!fetch || pte[PTE_EX])
                && (sup || pte[PTE_USR]);

        pte_upd          = pte;
        pte_upd[PTE_REF] = 1'b1;
        if (store) begin
            pte_upd[PTE_DIRTY] = 1'b1;
        end

        next_base = ppn << PAGE_SHIFT;
        page_base = (ppn | (vpn & low_mask)) << PAGE_SHIFT;
        pa_ok     = 64'(page_base) < MEM_BYTES;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int          XLEN      = 64,
    parameter logic [63:0] MEM_BYTES = 64'h100_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            walk_valid,
    output logic            walk_ready,
    input  logic [XLEN-1:0] walk_vaddr,
    input  logic            walk_super,
    input  logic            walk_fetch,
    input  logic            walk_store,
    input  logic [XLEN-1:0] root_base,
    output logic            walk_done,
    output logic            walk_fault,
    output logic [XLEN-1:0] walk_pbase,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic            mem_req_write,
    output logic [XLEN-1:0] mem_req_addr,
    output logic [XLEN-1:0] mem_req_wdata,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_rdata
);
    localparam int LEVELS   = (XLEN == 32) ? 2 : 3;
    localparam int IDX_BITS = (XLEN == 32) ? 10 : 9;
    localparam int PPN_LSB  = (XLEN == 32) ? 10 : 26;
    localparam int VA_BITS  = LEVELS * IDX_BITS + PAGE_SHIFT;
    localparam int LVL_W    = $clog2(LEVELS);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    typedef struct packed {
        walk_state_e      st;
        logic [LVL_W-1:0] lvl;
        logic [XLEN-1:0]  base;
        logic [XLEN-1:0]  va;
        logic [XLEN-1:0]  wdata;
        logic [XLEN-1:0]  pa;
        logic             pa_ok;
        logic             sup;
        logic             fet;
        logic             sto;
        logic             done;
        logic             fault;
        logic [XLEN-1:0]  pbase;
    } walk_regs_t;

    walk_regs_t q, d;

    logic            sign_ok;
    logic [XLEN-1:0] pte_addr;
    logic            pte_in_bounds;
    logic            is_table;
    logic            perm_ok;
    logic [XLEN-1:0] pte_upd;
    logic [XLEN-1:0] next_base;
    logic [XLEN-1:0] page_base;
    logic            pa_ok;

    generate
        if (VA_BITS < XLEN) begin : g_sext
            logic [XLEN-VA_BITS:0] hi_bits;
            assign hi_bits = walk_vaddr[XLEN-1:VA_BITS-1];
            assign sign_ok = (&hi_bits) || !(|hi_bits);
        end else begin : g_nosext
            assign sign_ok = 1'b1;
        end
    endgenerate

    ptw_index #(
        .XLEN(XLEN), .LEVELS(LEVELS), .IDX_BITS(IDX_BITS),
        .LVL_W(LVL_W), .MEM_BYTES(MEM_BYTES)
    ) u_index (
        .vaddr     (q.va),
        .base      (q.base),
        .level     (q.lvl),
        .pte_addr  (pte_addr),
        .in_bounds (pte_in_bounds)
    );

    ptw_leaf #(
        .XLEN(XLEN), .LEVELS(LEVELS), .IDX_BITS(IDX_BITS),
        .PPN_LSB(PPN_LSB), .LVL_W(LVL_W), .MEM_BYTES(MEM_BYTES)
    ) u_leaf (
        .pte       (mem_rsp_rdata),
        .vaddr     (q.va),
        .level     (q.lvl),
        .sup       (q.sup),
        .fetch     (q.fet),
        .store     (q.sto),
        .is_table  (is_table),
        .perm_ok   (perm_ok),
        .pte_upd   (pte_upd),
        .next_base (next_base),
        .page_base (page_base),
        .pa_ok     (pa_ok)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (walk_valid) begin
                    d.va   = walk_vaddr;
                    d.sup  = walk_super;
                    d.fet  = walk_fetch;
                    d.sto  = walk_store;
                    d.base = root_base;
                    d.lvl  = '0;
                    if (!sign_ok) begin
                        d.done  = 1'b1;
                        d.fault = 1'b1;
                        d.pbase = '0;
                    end else begin
                        d.st = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (!pte_in_bounds) begin
                    d.st    = ST_IDLE;
                    d.done  = 1'b1;
                    d.fault = 1'b1;
                    d.pbase = '0;
                end else if (mem_req_ready) begin
                    d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (is_table && (q.lvl != LAST_LVL)) begin
                        d.lvl  = q.lvl + LVL_W'(1);
                        d.base = next_base;
                        d.st   = ST_FETCH;
                    end else if (is_table || !perm_ok) begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.fault = 1'b1;
                        d.pbase = '0;
                    end else begin
                        d.wdata = pte_upd;
                        d.pa    = page_base;
                        d.pa_ok = pa_ok;
                        d.st    = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_req_ready) begin
                    d.st    = ST_IDLE;
                    d.done  = 1'b1;
                    d.fault = !q.pa_ok;
                    d.pbase = q.pa_ok ? q.pa : '0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign walk_ready    = (q.st == ST_IDLE);
    assign walk_done     = q.done;
    assign walk_fault    = q.fault;
    assign walk_pbase    = q.pbase;
    assign mem_req_valid = ((q.st == ST_FETCH) && pte_in_bounds) || (q.st == ST_WRITE);
    assign mem_req_write = (q.st == ST_WRITE);
    assign mem_req_addr  = pte_addr;
    assign mem_req_wdata = q.wdata;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int          XLEN      = 64,
    parameter logic [63:0] MEM_BYTES = 64'h100_0000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            walk_valid,
    input logic            walk_ready,
    input logic            walk_done,
    input logic            walk_fault,
    input logic [XLEN-1:0] walk_pbase,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic            mem_req_write,
    input logic [XLEN-1:0] mem_req_addr,
    input logic            wr_ref_bit
);
    a_r12_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        walk_valid && walk_ready |=> !walk_ready || walk_done);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        walk_ready |-> !mem_req_valid);

    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> walk_ready);

    a_r11_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done && walk_fault |-> walk_pbase == '0);

    a_r8_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done && !walk_fault |-> walk_pbase[11:0] == 12'd0);

    a_r9_pbase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done && !walk_fault |-> 64'(walk_pbase) < MEM_BYTES);

    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

    a_r4_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> 64'(mem_req_addr) < MEM_BYTES);

    a_r7_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> wr_ref_bit);
endmodule

bind ptw_walker ptw_walker_chk #(
    .XLEN(XLEN), .MEM_BYTES(MEM_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .walk_valid    (walk_valid),
    .walk_ready    (walk_ready),
    .walk_done     (walk_done),
    .walk_fault    (walk_fault),
    .walk_pbase    (walk_pbase),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .wr_ref_bit    (mem_req_wdata[ptw_pkg::PTE_REF])
);

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;
    localparam logic [63:0] MEMB = 64'h100_0000;
    localparam logic [63:0] ROOT = 64'h1000;
    localparam logic [63:0] VA_A = 64'h0000_0000_8060_5abc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        walk_valid = 1'b0;
    logic        walk_ready;
    logic [63:0] walk_vaddr = '0;
    logic        walk_super = 1'b0;
    logic        walk_fetch = 1'b0;
    logic        walk_store = 1'b0;
    logic        walk_done;
    logic        walk_fault;
    logic [63:0] walk_pbase;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic        mem_req_write;
    logic [63:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;

    int nchk = 0;
    int nfail = 0;
    logic [63:0] mem [logic [63:0]];
    logic [127:0] wr_q [$];

    always #5 clk = ~clk;

    ptw_walker #(.XLEN(64), .MEM_BYTES(MEMB)) u_ptw_walker (
        .clk(clk), .rst_n(rst_n),
        .walk_valid(walk_valid), .walk_ready(walk_ready),
        .walk_vaddr(walk_vaddr), .walk_super(walk_super),
        .walk_fetch(walk_fetch), .walk_store(walk_store),
        .root_base(ROOT),
        .walk_done(walk_done), .walk_fault(walk_fault), .walk_pbase(walk_pbase),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
    );

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    // memory: read data one cycle after acceptance, writes land on acceptance
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr] = mem_req_wdata;
                wr_q.push_back({mem_req_addr, mem_req_wdata});
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= rd(mem_req_addr);
            end
        end
    end

    function automatic logic [63:0] tpte(input logic [63:0] ppn);
        return (ppn << 26) | 64'h1;
    endfunction

    function automatic logic [63:0] lpte(input logic [63:0] ppn, input bit w, x, u);
        return (ppn << 26) | 64'h3 | (64'(w) << 2) | (64'(x) << 3) | (64'(u) << 4);
    endfunction

    // behavioural reference: result, due cycle and expected write-back
    function automatic void model(input logic [63:0] va, input bit sup, fe, st,
                                  output bit f, output logic [63:0] pa, output int n,
                                  output bit wr, output logic [63:0] wa, wd);
        logic [63:0] base = ROOT;
        logic [63:0] hi = va >> 38;
        f = 1'b1; pa = '0; wr = 1'b0; wa = '0; wd = '0;
        if (!(hi == 0 || hi == 64'h3FF_FFFF)) begin
            n = 0;
            return;
        end
        for (int k = 0; k < 3; k++) begin
            int sh = (2 - k) * 9;
            logic [63:0] idx = ((va >> 12) >> sh) & 64'h1FF;
            logic [63:0] a = base + idx * 8;
            logic [63:0] p;
            logic [63:0] ppn;
            bit ok;
            if (a >= MEMB) begin
                n = 2 * k + 1;
                return;
            end
            p = rd(a);
            ppn = p >> 26;
            if (p[0] && p[4:1] == 4'd0) begin
                if (k == 2) begin
                    n = 6;
                    return;
                end
                base = ppn << 12;
                continue;
            end
            ok = p[0] && (!st || p[2]) && (!fe || p[3]) && (sup || p[4]);
            if (!ok) begin
                n = 2 * k + 2;
                return;
            end
            wr = 1'b1; wa = a;
            wd = p | 64'h20 | (st ? 64'h40 : 64'h0);
            pa = (ppn | ((va >> 12) & ((64'd1 << sh) - 1))) << 12;
            n = 2 * k + 3;
            f = (pa >= MEMB);
            if (f) pa = '0;
            return;
        end
        n = 6;
    endfunction

    task automatic chk(input string tag, input string what, input logic [63:0] act, exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_walk(input string tag, input logic [63:0] va, input bit sup, fe, st,
                            input int stall, input bit poke);
        bit f, wr;
        logic [63:0] pa, wa, wd;
        int n;
        model(va, sup, fe, st, f, pa, n, wr, wa, wd);
        if (n > 1) n += stall;
        wr_q.delete();
        @(negedge clk);
        walk_vaddr = va; walk_super = sup; walk_fetch = fe; walk_store = st;
        walk_valid = 1'b1;
        mem_req_ready = (stall == 0);
        @(posedge clk);
        for (int cnt = 0; cnt <= n + 3; cnt++) begin
            if (cnt > 0) @(posedge clk);
            @(negedge clk);
            if (cnt == 0) walk_valid = 1'b0;
            if (cnt == stall) mem_req_ready = 1'b1;
            if (poke && cnt == 1) begin
                walk_vaddr = 64'h0000_0000_0012_3000; walk_valid = 1'b1;
            end
            if (poke && cnt == 2) walk_valid = 1'b0;
            if (stall > 0 && cnt < stall) chk(tag, "R10 request held", 64'(mem_req_valid), 64'd1);
            chk(tag, "R11 done timing", 64'(walk_done), 64'(cnt == n));
            chk(tag, "R12 ready", 64'(walk_ready), 64'(cnt >= n));
            if (cnt == n) begin
                chk(tag, "fault", 64'(walk_fault), 64'(f));
                chk(tag, "page base", walk_pbase, pa);
            end
        end
        chk(tag, "R7 write count", 64'(wr_q.size()), 64'(wr));
        if (wr && wr_q.size() == 1) begin
            chk(tag, "R3 write addr", wr_q[0][127:64], wa);
            chk(tag, "R7 write data", wr_q[0][63:0], wd);
        end
    endtask

    task automatic build_std(input logic [63:0] leaf);
        mem.delete();
        mem[ROOT + 16]     = tpte(2);
        mem[64'h2000 + 24] = tpte(3);
        mem[64'h3000 + 40] = leaf;
    endtask

    initial begin
        #2_000_000;
        nfail++;
        nchk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", "reset done", 64'(walk_done), 64'd0);
        chk("R12", "reset ready", 64'(walk_ready), 64'd1);
        chk("R12", "reset req", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;

        // R1 R3: three-level 4 KiB load
        build_std(lpte(64'h777, 0, 0, 0));
        run_walk("R1 R3", VA_A, 1, 0, 0, 0, 0);
        // R7: store sets dirty
        build_std(lpte(64'h777, 1, 0, 0));
        run_walk("R7", VA_A, 1, 0, 1, 0, 0);
        // R6 R10: user fetch with permission, stalled request
        build_std(lpte(64'h700, 0, 1, 1));
        run_walk("R6 R10", VA_A, 0, 1, 0, 3, 0);
        // R6: permission failures
        build_std(lpte(64'h777, 0, 1, 1));
        run_walk("R6", VA_A, 1, 0, 1, 0, 0);
        build_std(lpte(64'h777, 1, 1, 0));
        run_walk("R6", VA_A, 0, 0, 0, 0, 0);
        build_std(lpte(64'h777, 1, 0, 1));
        run_walk("R6", VA_A, 1, 1, 0, 0, 0);
        // R8: large pages at level 0 and level 1
        mem.delete();
        mem[ROOT] = lpte(0, 0, 0, 0);
        run_walk("R8", 64'h0000_0000_0012_3abc, 1, 0, 0, 0, 0);
        mem.delete();
        mem[ROOT] = tpte(2);
        mem[64'h2000 + 24] = lpte(64'h200, 0, 0, 0);
        run_walk("R8", (64'd3 << 21) | (64'h45 << 12), 1, 0, 0, 0, 0);
        // R2: bad and good sign extension
        run_walk("R2", 64'h0000_0040_0000_0000, 1, 0, 0, 0, 0);
        mem.delete();
        mem[ROOT + 64'h800] = lpte(64'h10, 0, 0, 0);
        run_walk("R2", 64'hFFFF_FFC0_0000_0000, 1, 0, 0, 0, 0);
        // R4: table entry out of memory
        mem.delete();
        mem[ROOT + 16] = tpte(64'h10_0000);
        run_walk("R4", VA_A, 1, 0, 0, 0, 0);
        // R9: final address out of memory, after write-back
        build_std(lpte(64'h1000, 0, 0, 0));
        run_walk("R9", VA_A, 1, 0, 0, 0, 0);
        // R5: pointer at last level
        build_std(tpte(4));
        run_walk("R5", VA_A, 1, 0, 0, 0, 0);
        // R6: invalid entry at level 1
        mem.delete();
        mem[ROOT + 16] = tpte(2);
        run_walk("R6", VA_A, 1, 0, 0, 0, 0);
        // R12: request during a walk is ignored
        build_std(lpte(64'h777, 0, 0, 0));
        run_walk("R12", VA_A, 1, 0, 0, 0, 1);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule